// File: doc/BRIEF.md
# Radio Slot Command Sequencer

This block runs the per-slot command traffic between a controller and a packet radio that sits behind a byte-level SPI master. An external scheduler gives it a one-cycle `slot_start` pulse with the slot kind and the hop channel number. The block then plays a fixed command script through the SPI port.

Every slot opens with three commands: an idle strobe, a channel register write and a rewrite of a synthesizer calibration register. A settle wait follows. After that the slot goes down one of two paths:

- **Receive slot:** the radio is put into receive. The block polls the receive byte count until a full 20-byte frame is present, then drains the frame in four burst reads of 1, 2, 15 and 2 bytes. Each data byte is presented on `rx_data` with its index.
- **Transmit slot:** both FIFOs are flushed. An 18-byte payload, fetched by index from `tx_byte`, is burst-written, and the transmit strobe is issued.

The slot ends with a `done` strobe. A receive slot that never sees a full frame ends instead with an `rx_timeout` strobe.

The SPI engine beneath the block moves one byte per handshake. The block holds `spi_req` with the byte to send until `spi_ack` returns the byte read in the same transfer. The block drives chip select itself, so that each command is framed as one unit. Settle and poll windows are counted in system clocks, and a parameter sets each one.

Top module: `radio_slot_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_req` is 0, and `busy`, `done`, `rx_timeout` and `rx_valid` are 0. While `busy` is 0, `spi_cs_n` stays 1 and `spi_req` stays 0.
- R2: A slot starts when `slot_start` is 1 while not busy. Its first three chip-select frames are, in order:
  - `[0x36]`
  - `[0x0A, chan]`, where chan is the `slot_chan` value latched at the start
  - `[0x23, 0x89]`
- R3: Chip select is low for every byte of a frame and stays low between those bytes. It goes high for at least one cycle between frames. `spi_req` is 1 only while `spi_cs_n` is 0, and `spi_tx` holds steady until `spi_ack`.
- R4: The frame after the calibration frame begins no fewer than SETTLE_RX_CLKS cycles (receive slot) or SETTLE_TX_CLKS cycles (transmit slot) after the calibration frame's chip select rises, and no more than 4 cycles later than that.
- R5: A receive slot (`slot_tx`=0) sends frame `[0x34]`. It then repeats poll frames `[0xFB, 0x00]`, where the second byte's reply is the count. The count is bits 6:0 of that reply, and bit 7 is ignored. Polling stops as soon as the count is at least 20.
- R6: After a successful poll, the block sends four frames: 0xFF followed by 1, 2, 15 and 2 bytes of 0x00. Each reply byte after a 0xFF header gives one `rx_valid` pulse. `rx_idx` runs 0 to 19 in order, and `rx_data` is that reply byte. The slot then ends with `done`.
- R7: If the count is still below 20 when a poll completes after POLL_LIMIT_CLKS cycles have passed since the 0x34 frame, no 0xFF frame is sent. `rx_timeout` pulses once and `done` does not pulse.
- R8: A transmit slot (`slot_tx`=1) sends, after the settle wait:
  - `[0x3A]`
  - `[0x3B]`
  - `[0x7F, p0..p17]`, where pN is `tx_byte` while `tx_idx`=N
  - `[0x35]`

  The slot then ends with `done`.
- R9: `done` and `rx_timeout` are one-cycle pulses, never high together. `busy` is 0 in the cycle they are high.
- R10: `slot_start` while busy is ignored. The running slot's frames and channel are unchanged, and no second slot follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | Begin a slot (taken only when idle) |
| slot_tx | input | 1 | Slot kind: 1 transmit, 0 receive |
| slot_chan | input | 8 | Hop channel number for the slot |
| tx_idx | output | 5 | Index of the payload byte wanted |
| tx_byte | input | 8 | Payload byte at `tx_idx` |
| rx_valid | output | 1 | Strobe: a received frame byte is on `rx_data` |
| rx_idx | output | 5 | Index of that byte in the frame (0..19) |
| rx_data | output | 8 | Received frame byte |
| done | output | 1 | Strobe: slot finished normally |
| rx_timeout | output | 1 | Strobe: receive slot gave up waiting |
| busy | output | 1 | A slot is in progress |
| spi_cs_n | output | 1 | Radio chip select, active low |
| spi_req | output | 1 | Byte transfer request to the SPI engine |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | One-cycle transfer-complete pulse |
| spi_rx | input | 8 | Byte shifted in, valid with `spi_ack` |

## Verification
The assertions take for granted that the SPI engine pulses `spi_ack` for exactly one cycle, only while `spi_req` is high, and never twice for one request. The bench's radio model keeps to this rule. It acks each request once, two cycles after seeing it, and waits for `spi_req` to drop before serving the next byte. It answers polls with a programmable run of short counts, including 19 and a count with bit 7 set, and answers burst reads with an indexed pattern. The receive checks can therefore be computed arithmetically.

// File: rtl/rss_pkg.sv
package rss_pkg;

  localparam int FRAME_BYTES = 20;
  localparam int TX_BYTES    = 18;

  typedef enum logic [3:0] {
    STP_IDLE, STP_CHAN, STP_CAL, STP_SRX, STP_POLL,
    STP_RD0, STP_RD1, STP_RD2, STP_RD3,
    STP_FRX, STP_FTX, STP_TXB, STP_STX
  } step_e;

  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_SETTLE} phase_e;

  // Command header byte of each step
  function automatic logic [7:0] seg_hdr(input step_e s);
    case (s)
      STP_IDLE: return 8'h36;
      STP_CHAN: return 8'h0A;
      STP_CAL:  return 8'h23;
      STP_SRX:  return 8'h34;
      STP_POLL: return 8'hFB;
      STP_RD0, STP_RD1, STP_RD2, STP_RD3: return 8'hFF;
      STP_FRX:  return 8'h3A;
      STP_FTX:  return 8'h3B;
      STP_TXB:  return 8'h7F;
      default:  return 8'h35;
    endcase
  endfunction

  // Bytes that follow the header inside the same chip-select frame
  function automatic logic [4:0] seg_len(input step_e s);
    case (s)
      STP_CHAN, STP_CAL, STP_POLL, STP_RD0: return 5'd1;
      STP_RD1, STP_RD3: return 5'd2;
      STP_RD2: return 5'd15;
      STP_TXB: return 5'(TX_BYTES);
      default: return 5'd0;
    endcase
  endfunction

  // Frame index of the first data byte of a burst read
  function automatic logic [4:0] rd_base(input step_e s);
    case (s)
      STP_RD1: return 5'd1;
      STP_RD2: return 5'd3;
      STP_RD3: return 5'd18;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic is_rd(input step_e s);
    return (s == STP_RD0) || (s == STP_RD1) || (s == STP_RD2) || (s == STP_RD3);
  endfunction

  function automatic step_e next_step(input step_e s);
    case (s)
      STP_IDLE: return STP_CHAN;
      STP_CHAN: return STP_CAL;
      STP_SRX:  return STP_POLL;
      STP_RD0:  return STP_RD1;
      STP_RD1:  return STP_RD2;
      STP_RD2:  return STP_RD3;
      STP_FRX:  return STP_FTX;
      STP_FTX:  return STP_TXB;
      STP_TXB:  return STP_STX;
      default:  return STP_IDLE;
    endcase
  endfunction

  // Polled count: low seven bits, overflow flag ignored
  function automatic logic count_ok(input logic [7:0] b);
    return b[6:0] >= 7'(FRAME_BYTES);
  endfunction

endpackage

// File: rtl/rss_delay.sv
module rss_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rss_spi_link.sv
module rss_spi_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] go_byte,
  input  logic       go_last,
  input  logic       spi_ack,
  input  logic [7:0] spi_rx,
  output logic       spi_req,
  output logic [7:0] spi_tx,
  output logic       spi_cs_n,
  output logic       byte_done,
  output logic [7:0] rx_q
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spi_req   <= 1'b0;
      spi_tx    <= 8'h00;
      spi_cs_n  <= 1'b1;
      byte_done <= 1'b0;
      rx_q      <= 8'h00;
      last_q    <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (go) begin
        spi_req  <= 1'b1;
        spi_tx   <= go_byte;
        spi_cs_n <= 1'b0;
        last_q   <= go_last;
      end else if (spi_req && spi_ack) begin
        spi_req   <= 1'b0;
        byte_done <= 1'b1;
        rx_q      <= spi_rx;
        if (last_q) spi_cs_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/radio_slot_seq.sv
module radio_slot_seq
  import rss_pkg::*;
#(
  parameter int SETTLE_RX_CLKS  = 69500,
  parameter int SETTLE_TX_CLKS  = 68500,
  parameter int POLL_LIMIT_CLKS = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_start,
  input  logic       slot_tx,
  input  logic [7:0] slot_chan,
  output logic [4:0] tx_idx,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [4:0] rx_idx,
  output logic [7:0] rx_data,
  output logic       done,
  output logic       rx_timeout,
  output logic       busy,
  output logic       spi_cs_n,
  output logic       spi_req,
  output logic [7:0] spi_tx,
  input  logic       spi_ack,
  input  logic [7:0] spi_rx
);
  localparam int SETTLE_MAX = (SETTLE_RX_CLKS > SETTLE_TX_CLKS) ? SETTLE_RX_CLKS : SETTLE_TX_CLKS;
  localparam int MAXV = (SETTLE_MAX > POLL_LIMIT_CLKS) ? SETTLE_MAX : POLL_LIMIT_CLKS;
  localparam int TW   = $clog2(MAXV + 1);

  phase_e     phase;
  step_e      step;
  logic [4:0] bcnt;
  logic [7:0] chan_q;
  logic       tx_q;

  // Named internal events
  logic       link_done, settle_exp, poll_exp, seg_last, seg_end, count_full;
  logic       go;
  logic [7:0] out_byte, link_rx;
  logic       settle_load, poll_load;
  logic [TW-1:0] settle_val;

  assign seg_last   = (bcnt == seg_len(step));
  assign seg_end    = (phase == PH_WAIT) && link_done && seg_last;
  assign count_full = count_ok(link_rx);
  assign go         = (phase == PH_ISSUE);

  always_comb begin
    if (bcnt == 5'd0) out_byte = seg_hdr(step);
    else begin
      case (step)
        STP_CHAN: out_byte = chan_q;
        STP_CAL:  out_byte = 8'h89;
        STP_TXB:  out_byte = tx_byte;
        default:  out_byte = 8'h00;
      endcase
    end
  end

  assign tx_idx      = (bcnt == 5'd0) ? 5'd0 : bcnt - 5'd1;
  assign settle_load = seg_end && (step == STP_CAL);
  assign settle_val  = tx_q ? TW'(SETTLE_TX_CLKS) : TW'(SETTLE_RX_CLKS);
  assign poll_load   = seg_end && (step == STP_SRX);
  assign busy        = (phase != PH_IDLE);
  assign rx_data     = link_rx;

  rss_spi_link u_link (
    .clk(clk), .rst_n(rst_n), .go(go), .go_byte(out_byte), .go_last(seg_last),
    .spi_ack(spi_ack), .spi_rx(spi_rx), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_cs_n(spi_cs_n), .byte_done(link_done), .rx_q(link_rx)
  );

  rss_delay #(.W(TW)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .load_val(settle_val), .expired(settle_exp)
  );

  rss_delay #(.W(TW)) u_poll (
    .clk(clk), .rst_n(rst_n), .load(poll_load), .load_val(TW'(POLL_LIMIT_CLKS)), .expired(poll_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      step       <= STP_IDLE;
      bcnt       <= 5'd0;
      chan_q     <= 8'h00;
      tx_q       <= 1'b0;
      done       <= 1'b0;
      rx_timeout <= 1'b0;
      rx_valid   <= 1'b0;
      rx_idx     <= 5'd0;
    end else begin
      done       <= 1'b0;
      rx_timeout <= 1'b0;
      rx_valid   <= 1'b0;
      case (phase)
        PH_IDLE: if (slot_start) begin
          chan_q <= slot_chan;
          tx_q   <= slot_tx;
          step   <= STP_IDLE;
          bcnt   <= 5'd0;
          phase  <= PH_ISSUE;
        end
        PH_ISSUE: phase <= PH_WAIT;
        PH_WAIT: if (link_done) begin
          if (is_rd(step) && bcnt != 5'd0) begin
            rx_valid <= 1'b1;
            rx_idx   <= rd_base(step) + bcnt - 5'd1;
          end
          if (!seg_last) begin
            bcnt  <= bcnt + 5'd1;
            phase <= PH_ISSUE;
          end else begin
            bcnt <= 5'd0;
            case (step)
              STP_CAL: begin
                step  <= tx_q ? STP_FRX : STP_SRX;
                phase <= PH_SETTLE;
              end
              STP_POLL: begin
                if (count_full) begin
                  step  <= STP_RD0;
                  phase <= PH_ISSUE;
                end else if (poll_exp) begin
                  rx_timeout <= 1'b1;
                  phase      <= PH_IDLE;
                end else begin
                  phase <= PH_ISSUE;
                end
              end
              STP_RD3, STP_STX: begin
                done  <= 1'b1;
                phase <= PH_IDLE;
              end
              default: begin
                step  <= next_step(step);
                phase <= PH_ISSUE;
              end
            endcase
          end
        end
        PH_SETTLE: if (settle_exp) phase <= PH_ISSUE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rss_sva.sv
module rss_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_req,
  input logic       spi_ack,
  input logic [7:0] spi_tx,
  input logic       spi_cs_n,
  input logic       busy,
  input logic       done,
  input logic       rx_timeout,
  input logic       rx_valid,
  input logic [4:0] rx_idx
);
  a_r3_req_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> !spi_cs_n);

  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !spi_req));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |=> !rx_timeout);

  a_r9_end_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done || rx_timeout) |-> !busy);

  a_r7_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rx_timeout));

  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_idx < 5'd20));
endmodule

bind radio_slot_seq rss_sva u_sva (
  .clk(clk), .rst_n(rst_n), .spi_req(spi_req), .spi_ack(spi_ack), .spi_tx(spi_tx),
  .spi_cs_n(spi_cs_n), .busy(busy), .done(done), .rx_timeout(rx_timeout),
  .rx_valid(rx_valid), .rx_idx(rx_idx)
);

// File: tb/radio_slot_seq_bench.sv
`timescale 1ns/1ps
module radio_slot_seq_bench;
  localparam int SRX = 40;
  localparam int STX = 30;
  localparam int PLIM = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_start = 1'b0, slot_tx = 1'b0;
  logic [7:0] slot_chan = 8'h00;
  logic [4:0] tx_idx;
  logic [7:0] tx_byte;
  logic rx_valid, done, rx_timeout, busy, spi_cs_n, spi_req;
  logic [4:0] rx_idx;
  logic [7:0] rx_data, spi_tx;
  logic spi_ack = 1'b0;
  logic [7:0] spi_rx = 8'h00;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] tx_pat(input logic [4:0] i);
    return 8'h5A ^ (8'(i) * 8'd13);
  endfunction
  assign tx_byte = tx_pat(tx_idx);

  radio_slot_seq #(.SETTLE_RX_CLKS(SRX), .SETTLE_TX_CLKS(STX), .POLL_LIMIT_CLKS(PLIM)) u_radio_slot_seq (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .slot_tx(slot_tx), .slot_chan(slot_chan),
    .tx_idx(tx_idx), .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_idx(rx_idx), .rx_data(rx_data),
    .done(done), .rx_timeout(rx_timeout), .busy(busy), .spi_cs_n(spi_cs_n), .spi_req(spi_req),
    .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Radio model and frame log
  int n_fr, cur_len, hi_cnt, start_gap, dly;
  int fr_len [64];
  int fr_gap [64];
  logic [7:0] fr_b [64][24];
  logic [7:0] cur_b [24];
  bit prev_cs = 1'b1, served = 1'b0;
  int poll_n, low_polls, rd_seq;
  logic [7:0] low_val, hi_val;
  int done_cnt, to_cnt, rxv_cnt, rxv_bad;

  initial begin
    forever begin
      @(negedge clk);
      if (prev_cs && !spi_cs_n) begin cur_len = 0; start_gap = hi_cnt; end
      if (!prev_cs && spi_cs_n) begin
        if (n_fr < 64) begin
          fr_len[n_fr] = cur_len;
          fr_gap[n_fr] = start_gap;
          for (int b = 0; b < 24; b++) fr_b[n_fr][b] = cur_b[b];
        end
        n_fr++;
        hi_cnt = 0;
      end
      if (spi_cs_n) hi_cnt++;
      prev_cs = spi_cs_n;
      if (spi_ack) spi_ack = 1'b0;
      else if (spi_req && !served) begin
        dly++;
        if (dly == 2) begin
          if (cur_len == 0) spi_rx = 8'h0F;
          else if (cur_b[0] == 8'hFB) begin
            spi_rx = (poll_n < low_polls) ? low_val : hi_val;
            poll_n++;
          end else if (cur_b[0] == 8'hFF) begin
            spi_rx = 8'hC0 + 8'(rd_seq);
            rd_seq++;
          end else spi_rx = 8'h00;
          if (cur_len < 24) cur_b[cur_len] = spi_tx;
          cur_len++;
          spi_ack = 1'b1;
          served = 1'b1;
          dly = 0;
        end
      end
      if (!spi_req) served = 1'b0;
      if (rx_valid) begin
        if (rx_idx != 5'(rxv_cnt) || rx_data != 8'hC0 + 8'(rxv_cnt)) rxv_bad++;
        rxv_cnt++;
      end
      if (done) done_cnt++;
      if (rx_timeout) to_cnt++;
    end
  end

  // Expected frames
  int exp_n;
  int exp_len [64];
  logic [7:0] exp_b [64][24];

  task automatic add1(input logic [7:0] h);
    exp_len[exp_n] = 1; exp_b[exp_n][0] = h; exp_n++;
  endtask
  task automatic add2(input logic [7:0] h, input logic [7:0] d);
    exp_len[exp_n] = 2; exp_b[exp_n][0] = h; exp_b[exp_n][1] = d; exp_n++;
  endtask

  task automatic build(input bit is_tx, input logic [7:0] ch, input int npolls);
    exp_n = 0;
    add1(8'h36); add2(8'h0A, ch); add2(8'h23, 8'h89);
    if (is_tx) begin
      add1(8'h3A); add1(8'h3B);
      exp_len[exp_n] = 19; exp_b[exp_n][0] = 8'h7F;
      for (int i = 0; i < 18; i++) exp_b[exp_n][i+1] = tx_pat(5'(i));
      exp_n++;
      add1(8'h35);
    end else begin
      add1(8'h34);
      for (int p = 0; p < npolls; p++) add2(8'hFB, 8'h00);
      add2(8'hFF, 8'h00);
      exp_len[exp_n] = 3; exp_b[exp_n][0] = 8'hFF; exp_b[exp_n][1] = 0; exp_b[exp_n][2] = 0; exp_n++;
      exp_len[exp_n] = 16; exp_b[exp_n][0] = 8'hFF;
      for (int i = 1; i < 16; i++) exp_b[exp_n][i] = 8'h00;
      exp_n++;
      exp_len[exp_n] = 3; exp_b[exp_n][0] = 8'hFF; exp_b[exp_n][1] = 0; exp_b[exp_n][2] = 0; exp_n++;
    end
  endtask

  task automatic cmp_frames(input string rq, input int upto);
    int lim;
    lim = (upto < exp_n) ? upto : exp_n;
    for (int f = 0; f < lim; f++) begin
      bit ok;
      ok = (f < n_fr) && (fr_len[f] == exp_len[f]);
      if (ok) for (int b = 0; b < exp_len[f]; b++) if (fr_b[f][b] !== exp_b[f][b]) ok = 0;
      chk(ok, rq, (f < n_fr) ? int'(fr_b[f][0]) : -1, int'(exp_b[f][0]));
    end
  endtask

  task automatic run_slot(input bit is_tx, input logic [7:0] ch, input int lowp,
                          input logic [7:0] lv, input logic [7:0] hv, input bit poke);
    int t;
    n_fr = 0; poll_n = 0; low_polls = lowp; low_val = lv; hi_val = hv; rd_seq = 0;
    done_cnt = 0; to_cnt = 0; rxv_cnt = 0; rxv_bad = 0;
    @(negedge clk);
    slot_tx = is_tx; slot_chan = ch; slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      slot_tx = ~is_tx; slot_chan = ch ^ 8'hFF; slot_start = 1'b1;
      @(negedge clk);
      slot_start = 1'b0;
    end
    t = 0;
    while (done_cnt + to_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (40) @(negedge clk);
    chk(t < 20000, "R9 slot end reached", t, 0);
  endtask

  task automatic check_rx(input logic [7:0] ch, input int lowp, input logic [7:0] lv,
                          input logic [7:0] hv, input bit poke);
    run_slot(1'b0, ch, lowp, lv, hv, poke);
    build(1'b0, ch, lowp + 1);
    chk(n_fr == exp_n, "R5 R6 frame count", n_fr, exp_n);
    cmp_frames("R2 R5 R6 rx frame bytes", 64);
    chk(fr_gap[3] >= SRX && fr_gap[3] <= SRX + 4, "R4 rx settle gap", fr_gap[3], SRX);
    chk(rxv_cnt == 20 && rxv_bad == 0, "R6 rx bytes", rxv_cnt, 20);
    chk(done_cnt == 1 && to_cnt == 0, "R9 done once", done_cnt, 1);
  endtask

  task automatic check_tx(input logic [7:0] ch);
    run_slot(1'b1, ch, 0, 8'h00, 8'h14, 1'b0);
    build(1'b1, ch, 0);
    chk(n_fr == exp_n, "R8 frame count", n_fr, exp_n);
    cmp_frames("R2 R8 tx frame bytes", 64);
    chk(fr_gap[3] >= STX && fr_gap[3] <= STX + 4, "R4 tx settle gap", fr_gap[3], STX);
    chk(done_cnt == 1 && rxv_cnt == 0, "R8 done once", done_cnt, 1);
  endtask

  initial begin
    int_loop_guard: begin end
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_req === 1'b0, "R1 spi idle in reset", {spi_cs_n, spi_req}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && !spi_req && !busy && !done && !rx_timeout && !rx_valid,
        "R1 reset state", {spi_cs_n, spi_req, busy, done}, 8);

    // receive, count ready at first poll
    check_rx(8'h53, 0, 8'h00, 8'h14, 1'b0);
    // receive, two short polls then count with overflow bit set (0x94 -> 20)
    check_rx(8'h08, 2, 8'h03, 8'h94, 1'b0);
    // transmit
    check_tx(8'hA3);

    // R7 timeout: count stuck at 19
    run_slot(1'b0, 8'h58, 1000, 8'h13, 8'h13, 1'b0);
    build(1'b0, 8'h58, 0);
    cmp_frames("R7 timeout prefix frames", 4);
    begin
      bit ok;
      ok = (n_fr >= 5);
      for (int f = 4; f < n_fr && f < 64; f++)
        if (fr_len[f] != 2 || fr_b[f][0] != 8'hFB) ok = 0;
      chk(ok, "R7 only polls, no burst reads", n_fr, 5);
    end
    chk(to_cnt == 1 && done_cnt == 0 && rxv_cnt == 0, "R7 timeout strobe", to_cnt, 1);

    // R10 start while busy ignored
    check_rx(8'h5D, 1, 8'h00, 8'h14, 1'b1);
    chk(n_fr == exp_n, "R10 no second slot", n_fr, exp_n);

    // Sweep over channels and slot kinds
    for (int k = 0; k < 6; k++) begin
      logic [7:0] ch;
      ch = 8'(k * 43 + 1);
      if (k % 3 == 2) check_tx(ch);
      else check_rx(ch, k % 3, 8'(k), 8'h14 + 8'(k), 1'b0);
    end

    @(negedge clk);
    chk(!busy && spi_cs_n, "R1 quiet after slots", busy, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule